// File: doc/BRIEF.md
# Single-Wire Bus Slave Front End

This block is the slave-side physical and link front end for a single open-drain line with a pull-up. It needs no separate clock line. It recovers every event from falling edges on the line and from delays counted in microsecond ticks after those edges. A low level that lasts long enough is a bus reset, and the block answers it with a presence pulse. Each later falling edge opens a time slot.

In a write slot the block samples the line once at a fixed delay and turns the sample into a bit. In a read slot it either holds the line low for a fixed time or leaves it alone. The choice follows a data bit supplied by the logic behind it. The block never drives the line high. Its only line output is an enable for an external pull-down.

Received bits are packed into bytes, least significant bit first. Each byte leaves on a valid-only stream: `rx_valid` is high for exactly one cycle with `rx_data`. There is no ready input, because the bus master cannot be stalled, so the consumer must take every byte in the cycle it is offered. When the first byte after a bus reset equals the skip-address command code, the block sets a level flag. That flag lets the command layer proceed without an address match.

Top module: `swb_slave`

## Requirements
- R1: A line low level lasting RST_MIN ticks (480 by default) is a bus reset in every state. It stops any drive within one cycle, clears the bit count of the partial byte, and clears `skip_rom`.
- R2: After a bus reset, once the line has risen, `pull_low` rises after PD_WAIT ticks (30 by default). This must fall within 15 to 60 µs.
- R3: The presence pulse holds `pull_low` high for PD_LEN ticks (120 by default), which is within 60 to 240 µs. It then releases the line.
- R4: In a write slot (`rd_mode` low at the falling edge), the line is sampled SAMPLE_AT ticks (30) after the falling edge. A low sample gives bit 0 and a high sample gives bit 1.
- R5: In a read slot (`rd_mode` high at the falling edge), `tx_bit` = 0 holds `pull_low` high from the edge for SAMPLE_AT ticks. `tx_bit` = 1 never asserts `pull_low`. Read slots add no received bit.
- R6: Write-slot bits are shifted in least significant bit first. After every 8th bit, `rx_data` carries the byte (bit 0 is the first bit received) and `rx_valid` is high for exactly one cycle. There is no back-pressure.
- R7: `skip_rom` rises, together with `rx_valid`, only when the first byte after a bus reset is 8'hCC. Bytes that follow never change it.
- R8: The block only enables a pull-down. `pull_low` is high only during the presence pulse or the low part of a read-0 slot.
- R9: After `rst_n` is released, `pull_low`, `rx_valid` and `skip_rom` are all low.
- R10: A low level shorter than RST_MIN ticks produces no presence pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| line_in | input | 1 | Asynchronous level of the bus line |
| rd_mode | input | 1 | Next slot is a read slot when high |
| tx_bit | input | 1 | Bit to send in a read slot, taken at the falling edge |
| pull_low | output | 1 | Enable for the external open-drain pull-down |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| skip_rom | output | 1 | First byte after the bus reset was the skip command |

## Verification
The bound checker checks four properties on every cycle:
- `rx_valid` never lasts more than one cycle.
- `skip_rom` only rises together with a valid 8'hCC byte.
- A bus reset clears the flag and enters the waiting state without drive.
- `pull_low` only appears in the presence or read-slot states.

Only the bench's scenarios can show the rest: the presence delay and width measured on the line, the bit values taken from slots of different lengths, the least-significant-first byte order, the clearing of a partial byte by a reset, and the absence of a presence pulse after a short low level.

// File: rtl/swb_pkg.sv
`timescale 1ns/1ps
package swb_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RSTL = 3'd1,
    S_PDW  = 3'd2,
    S_PDL  = 3'd3,
    S_SLOT = 3'd4
  } swb_state_e;
endpackage

// File: rtl/swb_sync.sv
`timescale 1ns/1ps
module swb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '1;
      prev <= 1'b1;
    end else begin
      sh   <= {sh[STAGES-2:0], line_in};
      prev <= sh[STAGES-1];
    end
  end

  assign line_s = sh[STAGES-1];
  assign fall   = prev & ~line_s;
  assign rise   = ~prev & line_s;
endmodule

// File: rtl/swb_lowtmr.sv
`timescale 1ns/1ps
module swb_lowtmr #(
  parameter int RST_MIN = 480,
  parameter int T_W     = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_s,
  output logic bus_rst
);
  logic [T_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || line_s) low_cnt <= '0;
    else if (tick && low_cnt < T_W'(RST_MIN)) low_cnt <= low_cnt + 1'b1;
  end

  assign bus_rst = (low_cnt >= T_W'(RST_MIN));
endmodule

// File: rtl/swb_slot.sv
`timescale 1ns/1ps
module swb_slot
  import swb_pkg::*;
#(
  parameter int PD_WAIT   = 30,
  parameter int PD_LEN    = 120,
  parameter int SAMPLE_AT = 30,
  parameter int T_W       = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_s,
  input  logic       fall,
  input  logic       rise,
  input  logic       bus_rst,
  input  logic       rd_mode,
  input  logic       tx_bit,
  output logic       pull_low,
  output logic       bit_vld,
  output logic       bit_val,
  output swb_state_e state
);
  swb_state_e     st;
  logic [T_W-1:0] t;
  logic           is_rd, drive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; t <= '0; is_rd <= 1'b0; drive <= 1'b0;
      bit_vld <= 1'b0; bit_val <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      if (bus_rst && st != S_RSTL) begin
        st <= S_RSTL; drive <= 1'b0;
      end else begin
        unique case (st)
          S_RSTL: if (rise) begin st <= S_PDW; t <= '0; end
          S_PDW: if (tick) begin
            if (t == T_W'(PD_WAIT - 1)) begin st <= S_PDL; t <= '0; drive <= 1'b1; end
            else t <= t + 1'b1;
          end
          S_PDL: if (tick) begin
            if (t == T_W'(PD_LEN - 1)) begin st <= S_IDLE; drive <= 1'b0; end
            else t <= t + 1'b1;
          end
          S_IDLE: if (fall) begin
            st <= S_SLOT; t <= '0; is_rd <= rd_mode;
            drive <= rd_mode & ~tx_bit;
          end
          S_SLOT: if (tick) begin
            if (t == T_W'(SAMPLE_AT - 1)) begin
              st <= S_IDLE; drive <= 1'b0;
              if (!is_rd) begin bit_vld <= 1'b1; bit_val <= line_s; end
            end else t <= t + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign pull_low = drive;
  assign state    = st;
endmodule

// File: rtl/swb_bytes.sv
`timescale 1ns/1ps
module swb_bytes #(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  SKIP_CODE = 8'hCC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              bit_vld,
  input  logic              bit_val,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              skip_rom
);
  localparam int CNT_W = $clog2(DATA_W);
  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              first;
  logic [DATA_W-1:0] nxt;

  assign nxt = {bit_val, sh[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; first <= 1'b0; rx_data <= '0;
      rx_valid <= 1'b0; skip_rom <= 1'b0;
    end else if (bus_rst) begin
      cnt <= '0; first <= 1'b1; skip_rom <= 1'b0; rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (bit_vld) begin
        sh <= nxt;
        if (cnt == CNT_W'(DATA_W - 1)) begin
          cnt <= '0; rx_data <= nxt; rx_valid <= 1'b1;
          if (first) begin
            skip_rom <= (nxt == DATA_W'(SKIP_CODE));
            first    <= 1'b0;
          end
        end else cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swb_slave.sv
`timescale 1ns/1ps
module swb_slave
  import swb_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         RST_MIN     = 480,
  parameter int         PD_WAIT     = 30,
  parameter int         PD_LEN      = 120,
  parameter int         SAMPLE_AT   = 30,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] SKIP_CODE   = 8'hCC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              line_in,
  input  logic              rd_mode,
  input  logic              tx_bit,
  output logic              pull_low,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              skip_rom
);
  localparam int T_MAX = (RST_MIN > PD_LEN) ? RST_MIN : PD_LEN;
  localparam int T_W   = $clog2(T_MAX + 1);

  logic       line_s, fall, rise, bus_rst, bit_vld, bit_val;
  swb_state_e state;

  swb_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .line_s(line_s), .fall(fall), .rise(rise));

  swb_lowtmr #(.RST_MIN(RST_MIN), .T_W(T_W)) lowtmr_i (
    .clk(clk), .rst_n(rst_n), .tick(us_tick), .line_s(line_s),
    .bus_rst(bus_rst));

  swb_slot #(.PD_WAIT(PD_WAIT), .PD_LEN(PD_LEN), .SAMPLE_AT(SAMPLE_AT),
             .T_W(T_W)) slot_i (
    .clk(clk), .rst_n(rst_n), .tick(us_tick), .line_s(line_s),
    .fall(fall), .rise(rise), .bus_rst(bus_rst), .rd_mode(rd_mode),
    .tx_bit(tx_bit), .pull_low(pull_low), .bit_vld(bit_vld),
    .bit_val(bit_val), .state(state));

  swb_bytes #(.DATA_W(DATA_W), .SKIP_CODE(SKIP_CODE)) bytes_i (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .bit_vld(bit_vld),
    .bit_val(bit_val), .rx_data(rx_data), .rx_valid(rx_valid),
    .skip_rom(skip_rom));
endmodule

// File: rtl/swb_slave_chk.sv
`timescale 1ns/1ps
module swb_slave_chk
  import swb_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter logic [7:0] SKIP_CODE = 8'hCC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pull_low,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              skip_rom,
  input logic              bus_rst,
  input swb_state_e        state
);
  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  skip_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(skip_rom) |-> (rx_valid && rx_data == DATA_W'(SKIP_CODE)));

  // R1
  skip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !skip_rom);

  // R1
  reset_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rst) |=> (state == S_RSTL && !pull_low));

  // R8
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> (state == S_PDL || state == S_SLOT));
endmodule

bind swb_slave swb_slave_chk #(.DATA_W(DATA_W), .SKIP_CODE(SKIP_CODE)) chk_i (
  .clk(clk), .rst_n(rst_n), .pull_low(pull_low), .rx_valid(rx_valid),
  .rx_data(rx_data), .skip_rom(skip_rom), .bus_rst(bus_rst), .state(state));

// File: tb/swb_slave_tb.sv
`timescale 1ns/1ps
module swb_slave_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0;
  logic m_low = 1'b0, rd_mode = 1'b0, tx_bit = 1'b0;
  logic pull_low, rx_valid, skip_rom;
  logic [7:0] rx_data;
  wire line = ~(m_low | pull_low);

  int nchk = 0, nfail = 0, got_n = 0, div = 0;
  logic [7:0] got_byte = 8'h00;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    div     <= (div == 3) ? 0 : div + 1;
    us_tick <= (div == 3);
  end

  always @(negedge clk) if (rx_valid) begin
    got_byte <= rx_data;
    got_n    <= got_n + 1;
  end

  swb_slave dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line),
    .rd_mode(rd_mode), .tx_bit(tx_bit), .pull_low(pull_low),
    .rx_data(rx_data), .rx_valid(rx_valid), .skip_rom(skip_rom));

  // [9] bus reset before the byte, [8:1] byte, [0] expected skip_rom after it
  localparam int NV = 7;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 8'hCC, 1'b1}, {1'b0, 8'h5A, 1'b1}, {1'b1, 8'hA5, 1'b0},
    {1'b0, 8'hCC, 1'b0}, {1'b1, 8'h33, 1'b0}, {1'b1, 8'hCD, 1'b0},
    {1'b1, 8'hCC, 1'b1}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic write_bit(input logic b);
    m_low = 1'b1;
    wait_us(b ? 5 : 60);
    m_low = 1'b0;
    wait_us(b ? 65 : 10);
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) write_bit(v[i]);
    wait_us(5);
  endtask

  task automatic bus_reset;
    int c;
    m_low = 1'b1;
    wait_us(500);
    m_low = 1'b0;
    c = 0;
    while (!pull_low && c < 400 * 4) begin @(negedge clk); c++; end
    chk(c / 4 >= 15 && c / 4 <= 60, "R2 presence delay us", c / 4, 30);
    c = 0;
    while (pull_low && c < 400 * 4) begin @(negedge clk); c++; end
    chk(c / 4 >= 60 && c / 4 <= 240, "R3 presence width us", c / 4, 120);
    wait_us(20);
  endtask

  initial begin
    int n0, c;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(!pull_low && !rx_valid && !skip_rom, "R9 outputs after reset",
        {pull_low, rx_valid, skip_rom}, 0);
    rst_n = 1'b1;
    wait_us(10);
    chk(!pull_low && !skip_rom, "R9 idle after release", {pull_low, skip_rom}, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][9]) bus_reset();
      n0 = got_n;
      write_byte(VEC[v][8:1]);
      chk(got_n == n0 + 1, "R6 one strobe per byte", got_n - n0, 1);
      chk(got_byte == VEC[v][8:1], "R4 R6 byte lsb first", got_byte, VEC[v][8:1]);
      chk(skip_rom == VEC[v][0], "R7 skip flag", skip_rom, VEC[v][0]);
    end

    // R1: a reset during a partial byte clears bit count and flag
    write_bit(1'b1); write_bit(1'b1); write_bit(1'b0);
    bus_reset();
    chk(!skip_rom, "R1 skip cleared by bus reset", skip_rom, 0);
    n0 = got_n;
    write_byte(8'hCC);
    chk(got_n == n0 + 1 && got_byte == 8'hCC, "R1 partial byte discarded", got_byte, 8'hCC);
    chk(skip_rom, "R1 R7 skip after fresh reset", skip_rom, 1);

    // R5: read slots
    rd_mode = 1'b1; tx_bit = 1'b0;
    n0 = got_n;
    m_low = 1'b1; wait_us(1); m_low = 1'b0;
    wait_us(14);
    chk(line == 1'b0, "R5 read0 holds line at 15us", line, 0);
    wait_us(30);
    chk(line == 1'b1, "R5 read0 released by 45us", line, 1);
    wait_us(25);
    tx_bit = 1'b1;
    c = 0;
    m_low = 1'b1; wait_us(1); m_low = 1'b0;
    for (int k = 0; k < 60 * 4; k++) begin @(negedge clk); if (pull_low) c++; end
    chk(c == 0, "R5 R8 read1 never pulls", c, 0);
    wait_us(10);
    chk(got_n == n0, "R5 read slots add no data", got_n - n0, 0);
    rd_mode = 1'b0; tx_bit = 1'b0;

    // R10: low shorter than reset threshold
    m_low = 1'b1; wait_us(400); m_low = 1'b0;
    c = 0;
    for (int k = 0; k < 300 * 4; k++) begin @(negedge clk); if (pull_low) c++; end
    chk(c == 0, "R10 no presence after 400us low", c, 0);
    chk(skip_rom, "R10 short low is not a reset", skip_rom, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(190000 * 4);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule